// File: doc/BRIEF.md
# Program Status Word Flag Unit

This block holds the eight-bit program status word of a small accumulator-based processor core. It keeps the arithmetic flags (carry, half carry, overflow) and two software flags. It also keeps a two-bit select for the working register bank. A parity bit is derived live from the accumulator. The ALU reports each finished operation through a one-cycle strobe that carries an operation class, the two operands and the upper byte of a multiply product. The unit works out the new flags from these inputs itself, so the ALU does not have to send flag bits.

Software reaches the word over the special-function-register bus at byte address 0xD0. It can write the whole byte, or write one bit through the bit addresses 0xD0 to 0xD7, where bit address 0xD0+n targets bit n. The unit outputs the word with parity folded in. It also outputs the base address of the selected register bank. With forwarding enabled, that base follows a bank-select write in the same cycle the write is presented. A one-cycle pulse after every change of the bank select lets a pipeline that does not forward hold back a banked-register access.

The ALU strobe and the bus strobes are plain control pins. The unit accepts one of each in every cycle and never stalls, so there is no back-pressure.

Top module: `psw_unit`

## Requirements
- R1: After reset, every stored bit is 0. With the accumulator at zero, the word reads 0x00, the bank base reads 0 and the bank-change pulse is low.
- R2: The word's layout from bit 7 down to bit 0 is: carry, half carry, user flag 0, bank select high, bank select low, overflow, user flag 1, parity. A byte write at address 0xD0 loads bits 7..1 from the write data. A byte write at any other address changes nothing.
- R3: A bit write at bit address 0xD0+n (n = 1..7) loads bit n with the written value. A bit address outside 0xD0..0xD7 changes nothing. User flags 0 and 1 change only through software writes.
- R4: The operation class is 0 = add, 1 = add with carry, 2 = subtract with borrow, 3 = multiply, 4 = divide, 5..7 = other. For add, and for add with carry (carry-in = stored carry), carry = carry out of bit 7. Half carry = carry out of bit 3. Overflow = signed overflow: both operands have the same sign and the result sign differs.
- R5: Subtract with borrow computes a - b - carry. Carry = borrow out of bit 7. Half carry = borrow out of bit 3. Overflow = the operand signs differ and the result sign differs from a.
- R6: Multiply sets overflow when the product's upper byte is nonzero, and clears it otherwise. Multiply clears carry and half carry.
- R7: Divide sets overflow when the divisor (operand b) is zero, and clears it otherwise. Divide clears carry and half carry.
- R8: Operation classes 5..7 leave carry, half carry and overflow unchanged. No ALU operation changes the user flags or the bank select.
- R9: Bit 0 is read-only. It is the XOR of the eight accumulator bits and follows the accumulator in the same cycle. Writes aimed at bit 0 are ignored.
- R10: The bank base is the bank select times 8, giving 0x00, 0x08, 0x10 or 0x18. With forwarding on (the default), a bank-select write shows on the base output in the cycle it is presented.
- R11: The bank-change pulse is high for exactly the one cycle after an edge that changed the bank select. Rewriting the same value gives no pulse.
- R12: When an ALU update and a software write fall in the same cycle, the software write decides the bits it targets. A byte write targets bits 7..1. A bit write targets only its own bit. The ALU still sets the other flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_valid | input | 1 | ALU operation completes this cycle |
| alu_op | input | 3 | Operation class (encoding in R4) |
| alu_a | input | 8 | First operand |
| alu_b | input | 8 | Second operand (divisor for divide) |
| alu_mul_hi | input | 8 | Upper byte of the multiply product |
| acc | input | 8 | Current accumulator value |
| sfr_addr | input | 8 | Byte address for a byte write |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| bit_addr | input | 8 | Bit address for a single-bit write |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_wdata | input | 1 | Value for the single-bit write |
| psw_q | output | 8 | Status word with live parity in bit 0 |
| bank_base | output | 5 | Base address of the working register bank |
| bank_chg | output | 1 | One-cycle pulse after a bank-select change |

## Verification
The ALU flag update and a software write can land in the same cycle. The bench provokes this twice. First, an add that produces carry and half carry is issued together with a bit write that clears carry. The result must keep half carry from the ALU and take carry from the software write. Second, a byte write is presented alongside an add that would set overflow. The stored bits must equal the written byte. The forwarded bank base is judged inside the cycle that carries the write, before the clock edge.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int DW = 8;
  localparam logic [7:0] PSW_SFR = 8'hD0;

  localparam int CY_B  = 7;
  localparam int AC_B  = 6;
  localparam int F0_B  = 5;
  localparam int RSH_B = 4;
  localparam int RSL_B = 3;
  localparam int OV_B  = 2;
  localparam int F1_B  = 1;
  localparam int PAR_B = 0;

  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDC = 3'd1;
  localparam logic [2:0] OP_SUBB = 3'd2;
  localparam logic [2:0] OP_MUL  = 3'd3;
  localparam logic [2:0] OP_DIV  = 3'd4;

  typedef struct packed {
    logic upd;
    logic cy;
    logic ac;
    logic ov;
  } flag_upd_t;
endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
(
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] mul_hi,
  input  logic          cin,
  output flag_upd_t     upd
);
  localparam int NW = DW / 2;

  logic          cin_eff;
  logic [DW:0]   sum_w, dif_w;
  logic [NW:0]   sum_n, dif_n;
  logic          add_ov, sub_ov;

  always_comb begin
    cin_eff = (op == OP_ADDC || op == OP_SUBB) ? cin : 1'b0;
    sum_w = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin_eff};
    dif_w = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin_eff};
    sum_n = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin_eff};
    dif_n = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin_eff};
    add_ov = (a[DW-1] == b[DW-1]) && (sum_w[DW-1] != a[DW-1]);
    sub_ov = (a[DW-1] != b[DW-1]) && (dif_w[DW-1] != a[DW-1]);
  end

  always_comb begin
    upd = '0;
    if (valid) begin
      unique case (op)
        OP_ADD, OP_ADDC: begin
          upd.upd = 1'b1;
          upd.cy  = sum_w[DW];
          upd.ac  = sum_n[NW];
          upd.ov  = add_ov;
        end
        OP_SUBB: begin
          upd.upd = 1'b1;
          upd.cy  = dif_w[DW];
          upd.ac  = dif_n[NW];
          upd.ov  = sub_ov;
        end
        OP_MUL: begin
          upd.upd = 1'b1;
          upd.ov  = |mul_hi;
        end
        OP_DIV: begin
          upd.upd = 1'b1;
          upd.ov  = ~|b;
        end
        default: upd = '0;
      endcase
    end
  end
endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  output logic         odd
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ data[i];
  end
  assign odd = chain[W];
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
  parameter int BANK_REGS = 8,
  parameter bit FWD       = 1'b1,
  localparam int SH       = $clog2(BANK_REGS),
  localparam int AW       = 2 + SH
) (
  input  logic [1:0]    sel_q,
  input  logic [1:0]    sel_next,
  output logic [AW-1:0] base
);
  logic [1:0] sel;
  if (FWD) begin : g_fwd
    assign sel = sel_next;
  end else begin : g_reg
    assign sel = sel_q;
  end
  assign base = {sel, {SH{1'b0}}};
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int BANK_REGS = 8,
  parameter bit BANK_FWD  = 1'b1,
  localparam int BASE_W   = 2 + $clog2(BANK_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_valid,
  input  logic [2:0]        alu_op,
  input  logic [DW-1:0]     alu_a,
  input  logic [DW-1:0]     alu_b,
  input  logic [DW-1:0]     alu_mul_hi,
  input  logic [DW-1:0]     acc,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  input  logic [7:0]        bit_addr,
  input  logic              bit_wr,
  input  logic              bit_wdata,
  output logic [DW-1:0]     psw_q,
  output logic [BASE_W-1:0] bank_base,
  output logic              bank_chg
);
  logic [DW-1:1] st_q, st_nxt;
  logic          chg_q;
  logic          par;
  logic          byte_hit, bit_hit;
  flag_upd_t     fu;

  psw_flag_calc u_calc (
    .valid  (alu_valid),
    .op     (alu_op),
    .a      (alu_a),
    .b      (alu_b),
    .mul_hi (alu_mul_hi),
    .cin    (st_q[CY_B]),
    .upd    (fu)
  );

  psw_parity #(.W(DW)) u_par (
    .data (acc),
    .odd  (par)
  );

  psw_bank_map #(.BANK_REGS(BANK_REGS), .FWD(BANK_FWD)) u_bank (
    .sel_q    (st_q[RSH_B:RSL_B]),
    .sel_next (st_nxt[RSH_B:RSL_B]),
    .base     (bank_base)
  );

  assign byte_hit = sfr_wr && (sfr_addr == PSW_SFR);
  assign bit_hit  = bit_wr && (bit_addr[7:3] == PSW_SFR[7:3]) && (bit_addr[2:0] != 3'd0);

  always_comb begin
    st_nxt = st_q;
    if (fu.upd) begin
      st_nxt[CY_B] = fu.cy;
      st_nxt[AC_B] = fu.ac;
      st_nxt[OV_B] = fu.ov;
    end
    if (byte_hit) st_nxt = sfr_wdata[DW-1:1];
    if (bit_hit)  st_nxt[bit_addr[2:0]] = bit_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      chg_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      chg_q <= (st_nxt[RSH_B:RSL_B] != st_q[RSH_B:RSL_B]);
    end
  end

  assign psw_q    = {st_q, par};
  assign bank_chg = chg_q;
endmodule

// File: rtl/psw_checker.sv
module psw_checker
  import psw_pkg::*;
#(
  parameter int BASE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alu_valid,
  input logic [2:0]        alu_op,
  input logic [DW-1:0]     alu_b,
  input logic [DW-1:0]     acc,
  input logic [7:0]        sfr_addr,
  input logic              sfr_wr,
  input logic [DW-1:0]     sfr_wdata,
  input logic [7:0]        bit_addr,
  input logic              bit_wr,
  input logic [DW-1:0]     psw_q,
  input logic [BASE_W-1:0] bank_base
);
  logic sw_any;
  assign sw_any = (sfr_wr && sfr_addr == PSW_SFR) ||
                  (bit_wr && bit_addr[7:3] == PSW_SFR[7:3]);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> psw_q[DW-1:1] == '0);

  assert_byte_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == PSW_SFR && !bit_wr) |=> psw_q[DW-1:1] == $past(sfr_wdata[DW-1:1]));

  assert_user_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_any |=> $stable(psw_q[F0_B]) && $stable(psw_q[F1_B]) && $stable(psw_q[RSH_B:RSL_B]));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op == OP_DIV && alu_b == '0 && !sw_any)
      |=> psw_q[OV_B] && !psw_q[CY_B] && !psw_q[AC_B]);

  assert_other_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && alu_op > OP_DIV && !sw_any)
      |=> $stable(psw_q[CY_B]) && $stable(psw_q[AC_B]) && $stable(psw_q[OV_B]));

  assert_parity_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    psw_q[PAR_B] == ^acc);

  assert_bank_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_any |-> bank_base == {psw_q[RSH_B:RSL_B], {(BASE_W-2){1'b0}}});
endmodule

bind psw_unit psw_checker #(.BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .alu_valid (alu_valid),
  .alu_op    (alu_op),
  .alu_b     (alu_b),
  .acc       (acc),
  .sfr_addr  (sfr_addr),
  .sfr_wr    (sfr_wr),
  .sfr_wdata (sfr_wdata),
  .bit_addr  (bit_addr),
  .bit_wr    (bit_wr),
  .psw_q     (psw_q),
  .bank_base (bank_base)
);

// File: tb/sim_psw_unit.sv
module sim_psw_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alu_valid = 1'b0;
  logic [2:0] alu_op = 3'd0;
  logic [7:0] alu_a = 8'h00, alu_b = 8'h00, alu_mul_hi = 8'h00, acc = 8'h00;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00, bit_addr = 8'h00;
  logic       sfr_wr = 1'b0, bit_wr = 1'b0, bit_wdata = 1'b0;
  logic [7:0] psw_q;
  logic [4:0] bank_base;
  logic       bank_chg;

  int n_chk = 0;
  int n_fail = 0;

  psw_unit u0 (
    .clk(clk), .rst_n(rst_n), .alu_valid(alu_valid), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_mul_hi(alu_mul_hi), .acc(acc),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_wdata(bit_wdata),
    .psw_q(psw_q), .bank_base(bank_base), .bank_chg(bank_chg)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_valid = 1'b0; sfr_wr = 1'b0; bit_wr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic byte_wr(input logic [7:0] adr, input logic [7:0] d);
    sfr_addr = adr; sfr_wdata = d; sfr_wr = 1'b1;
    step();
  endtask

  task automatic bit_write(input logic [7:0] adr, input logic v);
    bit_addr = adr; bit_wdata = v; bit_wr = 1'b1;
    step();
  endtask

  task automatic alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] hi);
    alu_valid = 1'b1; alu_op = op; alu_a = a; alu_b = b; alu_mul_hi = hi;
    step();
  endtask

  task automatic t_reset();
    check("R1 word", psw_q, 8'h00);
    check("R1 base", {3'b0, bank_base}, 8'h00);
    check("R1 chg", {7'b0, bank_chg}, 8'h00);
  endtask

  task automatic t_byte();
    byte_wr(8'hD0, 8'hFF);
    check("R2 byte load", psw_q, 8'hFE);
    check("R10 base bank3", {3'b0, bank_base}, 8'h18);
    byte_wr(8'hD1, 8'h00);
    check("R2 other address", psw_q, 8'hFE);
    byte_wr(8'hD0, 8'h00);
    check("R2 clear", psw_q, 8'h00);
  endtask

  task automatic t_bit();
    bit_write(8'hD5, 1'b1);
    check("R3 set F0", psw_q, 8'h20);
    bit_write(8'hD0, 1'b1);
    check("R9 parity write ignored", psw_q, 8'h20);
    bit_write(8'hD8, 1'b1);
    check("R3 outside range", psw_q, 8'h20);
    bit_write(8'hD1, 1'b1);
    check("R3 set F1", psw_q, 8'h22);
    bit_write(8'hD5, 1'b0);
    check("R3 clear F0", psw_q, 8'h02);
  endtask

  task automatic t_add();
    byte_wr(8'hD0, 8'h02);
    alu(3'd0, 8'h7F, 8'h01, 8'h00);
    check("R4 add signed ovf", psw_q, 8'h46);
    alu(3'd0, 8'hFF, 8'h01, 8'h00);
    check("R4 add carry", psw_q, 8'hC2);
    alu(3'd1, 8'h0F, 8'h00, 8'h00);
    check("R4 addc uses carry", psw_q, 8'h42);
    check("R8 user flag kept", {7'b0, psw_q[1]}, 8'h01);
  endtask

  task automatic t_subb();
    byte_wr(8'hD0, 8'h02);
    alu(3'd2, 8'h10, 8'h01, 8'h00);
    check("R5 subb half borrow", psw_q, 8'h42);
    alu(3'd2, 8'h00, 8'h01, 8'h00);
    check("R5 subb borrow", psw_q, 8'hC2);
    alu(3'd2, 8'h80, 8'h00, 8'h00);
    check("R5 subb ovf with borrow in", psw_q, 8'h46);
  endtask

  task automatic t_muldiv();
    byte_wr(8'hD0, 8'hC2);
    alu(3'd3, 8'h10, 8'h10, 8'h01);
    check("R6 mul ovf", psw_q, 8'h06);
    alu(3'd3, 8'h03, 8'h04, 8'h00);
    check("R6 mul fits", psw_q, 8'h02);
    byte_wr(8'hD0, 8'hC2);
    alu(3'd4, 8'h09, 8'h00, 8'h00);
    check("R7 div by zero", psw_q, 8'h06);
    alu(3'd4, 8'h09, 8'h03, 8'h00);
    check("R7 div ok", psw_q, 8'h02);
  endtask

  task automatic t_other();
    byte_wr(8'hD0, 8'h2A);
    alu(3'd0, 8'h88, 8'h88, 8'h00);
    check("R4 all flags", psw_q, 8'hEE);
    for (int k = 5; k < 8; k++) begin
      alu(k[2:0], 8'h00, 8'h00, 8'h00);
      check("R8 other op hold", psw_q, 8'hEE);
    end
  endtask

  task automatic t_parity();
    byte_wr(8'hD0, 8'h00);
    acc = 8'h01; #1;
    check("R9 odd", psw_q, 8'h01);
    acc = 8'h03; #1;
    check("R9 even", psw_q, 8'h00);
    acc = 8'hFE; #1;
    check("R9 seven ones", psw_q, 8'h01);
    step();
    acc = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_bank();
    byte_wr(8'hD0, 8'h00);
    step();
    sfr_addr = 8'hD0; sfr_wdata = 8'h10; sfr_wr = 1'b1; #1;
    check("R10 forwarded base", {3'b0, bank_base}, 8'h10);
    step();
    check("R10 base bank2", {3'b0, bank_base}, 8'h10);
    check("R11 pulse", {7'b0, bank_chg}, 8'h01);
    step();
    check("R11 pulse one cycle", {7'b0, bank_chg}, 8'h00);
    byte_wr(8'hD0, 8'h10);
    check("R11 same value no pulse", {7'b0, bank_chg}, 8'h00);
    bit_write(8'hD3, 1'b1);
    check("R10 base bank3 via bit", {3'b0, bank_base}, 8'h18);
    check("R11 pulse bit write", {7'b0, bank_chg}, 8'h01);
  endtask

  task automatic t_collide();
    byte_wr(8'hD0, 8'h00);
    alu_valid = 1'b1; alu_op = 3'd0; alu_a = 8'hFF; alu_b = 8'h01;
    bit_addr = 8'hD7; bit_wdata = 1'b0; bit_wr = 1'b1;
    step();
    check("R12 bit write beats carry", psw_q, 8'h40);
    alu_valid = 1'b1; alu_op = 3'd0; alu_a = 8'h7F; alu_b = 8'h01;
    sfr_addr = 8'hD0; sfr_wdata = 8'h20; sfr_wr = 1'b1;
    step();
    check("R12 byte write beats ALU", psw_q, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte();
    t_bit();
    t_add();
    t_subb();
    t_muldiv();
    t_other();
    t_parity();
    t_bank();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule